// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block takes one ARINC 429 receive channel and turns its bipolar return-to-zero bit stream into a parallel word. The two inputs are the already level-translated halves of the differential line: one goes high for a logic one and the other goes high for a logic zero. Both inputs are sampled on an internal tick that runs at ten times the bit rate. The tick comes from the master clock divided by 10, or by 80 for the low-speed rate. A line state counts only once two consecutive samples agree. A bit is taken each time the line moves from null to a data state.

A word is either 32 or 25 bits long. The first bit received lands in the least significant position. Once the null after the last bit is confirmed, the block computes a parity status for the word. It can then apply a two-bit source/destination match on word bits 9 and 10, and it pulses a one-clock strobe with the word on the output. A word that is broken off part way is dropped without a strobe, either by a long null or by an illegal line state. A self-test input switches the sampler from the line pins to a loopback pair fed by a local transmitter. A parameter chooses whether that pair is taken as true or as inverted polarity.

The configuration inputs are static. Change them only while the line is idle between words.

Top module: `arinc_word_rx`

## Requirements
- R1: While `rstN` is low, `wordValid`, `wordData` and `parityEven` are all 0.
- R2: With `cfgSlow`=0 the sample tick comes every 10 clocks, and with `cfgSlow`=1 every 80 clocks. At either rate, words sent with 10 ticks per bit (5 ticks data, 5 ticks null) are received correctly.
- R3: The input pair {hi,lo} encodes 2'b10 as one, 2'b01 as zero, 2'b00 as null and 2'b11 as illegal. A state is accepted only after two consecutive equal samples, and a bit is taken when the accepted state changes from null to one or zero.
- R4: In 32-bit mode (`cfgShort`=0) the first bit received appears in `wordData[0]` and the 32nd in `wordData[31]`.
- R5: In 25-bit mode (`cfgShort`=1) the 25 bits fill `wordData[24:0]`, first bit in bit 0, and `wordData[31:25]` reads 0.
- R6: `wordValid` is high for exactly one clock. That clock follows the sample tick on which the null after the last bit is accepted, which is the second null sample.
- R7: When a word is delivered, `parityEven` is 1 if the word holds an even number of ones and 0 if it holds an odd number. The word is delivered in both cases.
- R8: With `cfgFilterEn`=1 in 32-bit mode, a word is delivered only if `wordData[8]`==`cfgX` and `wordData[9]`==`cfgY`. A rejected word gives no strobe and changes no output. With the filter off, or in 25-bit mode, `cfgX` and `cfgY` have no effect.
- R9: If a word in progress sees a null run of 20 or more sample ticks (two bit times), the partial word is discarded. A run of 19 ticks or fewer keeps it.
- R10: An accepted illegal state (2'b11) discards the word in progress. The next word after a null is received normally.
- R11: With `selfTest`=1 the sampler reads `loopHi`/`loopLo`, and the line pins have no effect. With `LOOP_INVERT`=1 the loop pair is swapped, so the delivered word is the bitwise complement of the word sent.
- R12: `wordData` and `parityEven` keep their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineHi | input | 1 | Line half that is high for a one |
| lineLo | input | 1 | Line half that is high for a zero |
| loopHi | input | 1 | Loopback half that is high for a one |
| loopLo | input | 1 | Loopback half that is high for a zero |
| selfTest | input | 1 | 1 selects the loopback pair |
| cfgSlow | input | 1 | 1 selects the divide-by-80 sample tick |
| cfgShort | input | 1 | 1 selects 25-bit words |
| cfgFilterEn | input | 1 | 1 enables the bit 9/10 match |
| cfgX | input | 1 | Required value of word bit 9 |
| cfgY | input | 1 | Required value of word bit 10 |
| wordValid | output | 1 | One-clock strobe for a delivered word |
| wordData | output | 32 | Last delivered word |
| parityEven | output | 1 | 1 when the delivered word has an even count of ones |

## Verification
Two functions can act on the same sample tick. The timeout that ends an interrupted word can expire on the very tick where the first sample of the next bit still reads as null, because that sample has not yet been confirmed. The bench holds a mid-word null for exactly 19 ticks and then for exactly 20. The word must survive the first case and vanish in the second. A behavioural model in the bench tracks tick phase, symbol confirmation and the bit queue. It is compared with the strobe, word and parity on every clock, so a shift of the timeout boundary by one tick shows up as a missing or extra strobe.

// File: rtl/arinc_word_rx_pkg.sv
`timescale 1ns/1ps
package arinc_word_rx_pkg;
  localparam int LONG_LEN  = 32;
  localparam int SHORT_LEN = 25;
  localparam int SD_LOW    = 8;   // word bit 9 sits at index 8, bit 10 at index 9

  typedef enum logic [1:0] {
    SYM_NULL = 2'b00,
    SYM_ZERO = 2'b01,
    SYM_ONE  = 2'b10,
    SYM_BAD  = 2'b11
  } lineSym_e;

  typedef struct packed {
    logic shiftIn;
    logic dropWord;
    logic publish;
  } ctlStrobe_t;
endpackage

// File: rtl/arinc_word_rx_dp.sv
`timescale 1ns/1ps
module arinc_word_rx_dp
  import arinc_word_rx_pkg::*;
#(
  parameter int BASE_DIV    = 10,
  parameter int SLOW_MULT   = 8,
  parameter int LOOP_INVERT = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineHi,
  input  logic             lineLo,
  input  logic             loopHi,
  input  logic             loopLo,
  input  logic             selfTest,
  input  logic             cfgSlow,
  input  logic             cfgShort,
  input  logic             cfgFilterEn,
  input  logic             cfgX,
  input  logic             cfgY,
  input  ctlStrobe_t       strobe,
  output logic             sampleTick,
  output lineSym_e         candSym,
  output lineSym_e         heldSym,
  output logic             wordValid,
  output logic [LONG_LEN-1:0] wordData,
  output logic             parityEven
);
  localparam int SLOW_DIV = BASE_DIV * SLOW_MULT;
  localparam int DIV_W    = $clog2(SLOW_DIV);
  localparam int PAD      = LONG_LEN - SHORT_LEN;

  // sample tick divider
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  assign divLim     = cfgSlow ? DIV_W'(SLOW_DIV - 1) : DIV_W'(BASE_DIV - 1);
  assign sampleTick = (divCnt >= divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= sampleTick ? '0 : divCnt + DIV_W'(1);
  end

  // source selection, polarity chosen at build time
  logic [1:0] loopPair;
  generate
    if (LOOP_INVERT != 0) begin : g_loopInv
      assign loopPair = {loopLo, loopHi};
    end else begin : g_loopTrue
      assign loopPair = {loopHi, loopLo};
    end
  endgenerate

  lineSym_e rawSym;
  lineSym_e prevSym;
  assign rawSym  = lineSym_e'(selfTest ? loopPair : {lineHi, lineLo});
  assign candSym = (rawSym == prevSym) ? rawSym : heldSym;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSym <= SYM_NULL;
      heldSym <= SYM_NULL;
    end else if (sampleTick) begin
      prevSym <= rawSym;
      heldSym <= candSym;
    end
  end

  // bit assembly: first bit travels down to the low end
  logic [LONG_LEN-1:0] shiftReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                shiftReg <= '0;
    else if (strobe.dropWord || strobe.publish) shiftReg <= '0;
    else if (strobe.shiftIn)                  shiftReg <= {candSym == SYM_ONE, shiftReg[LONG_LEN-1:1]};
  end

  logic [LONG_LEN-1:0] aligned;
  logic                filterPass;
  assign aligned    = cfgShort ? (shiftReg >> PAD) : shiftReg;
  assign filterPass = !cfgFilterEn || cfgShort ||
                      ((aligned[SD_LOW] == cfgX) && (aligned[SD_LOW+1] == cfgY));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid  <= 1'b0;
      wordData   <= '0;
      parityEven <= 1'b0;
    end else begin
      wordValid <= strobe.publish && filterPass;
      if (strobe.publish && filterPass) begin
        wordData   <= aligned;
        parityEven <= ~^aligned;
      end
    end
  end
endmodule

// File: rtl/arinc_word_rx_ctl.sv
`timescale 1ns/1ps
module arinc_word_rx_ctl
  import arinc_word_rx_pkg::*;
#(
  parameter int GAP_TICKS = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgShort,
  input  logic       sampleTick,
  input  lineSym_e   candSym,
  input  lineSym_e   heldSym,
  output ctlStrobe_t strobe
);
  localparam int CNT_W = $clog2(LONG_LEN + 1);
  localparam int RUN_W = $clog2(GAP_TICKS + 1);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] wordLen;
  logic [RUN_W-1:0] nullRun;

  assign wordLen = cfgShort ? CNT_W'(SHORT_LEN) : CNT_W'(LONG_LEN);

  always_comb begin
    strobe = '0;
    if (sampleTick) begin
      case (candSym)
        SYM_BAD:  strobe.dropWord = 1'b1;
        SYM_NULL: begin
          if (heldSym != SYM_NULL && bitCnt == wordLen)
            strobe.publish = 1'b1;
          else if (bitCnt != '0 && nullRun >= RUN_W'(GAP_TICKS - 1))
            strobe.dropWord = 1'b1;
        end
        default: begin
          if (heldSym == SYM_NULL && bitCnt < wordLen)
            strobe.shiftIn = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      nullRun <= '0;
    end else if (sampleTick) begin
      if (strobe.dropWord || strobe.publish) bitCnt <= '0;
      else if (strobe.shiftIn)               bitCnt <= bitCnt + CNT_W'(1);
      if (candSym != SYM_NULL)               nullRun <= '0;
      else if (nullRun < RUN_W'(GAP_TICKS))  nullRun <= nullRun + RUN_W'(1);
    end
  end
endmodule

// File: rtl/arinc_word_rx.sv
`timescale 1ns/1ps
module arinc_word_rx
  import arinc_word_rx_pkg::*;
#(
  parameter int BASE_DIV        = 10,
  parameter int SLOW_MULT       = 8,
  parameter int SAMPLES_PER_BIT = 10,
  parameter int GAP_BITS        = 2,
  parameter int LOOP_INVERT     = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineHi,
  input  logic        lineLo,
  input  logic        loopHi,
  input  logic        loopLo,
  input  logic        selfTest,
  input  logic        cfgSlow,
  input  logic        cfgShort,
  input  logic        cfgFilterEn,
  input  logic        cfgX,
  input  logic        cfgY,
  output logic        wordValid,
  output logic [31:0] wordData,
  output logic        parityEven
);
  localparam int GAP_TICKS = GAP_BITS * SAMPLES_PER_BIT;

  ctlStrobe_t strobe;
  logic       sampleTick;
  lineSym_e   candSym;
  lineSym_e   heldSym;

  arinc_word_rx_dp #(
    .BASE_DIV(BASE_DIV), .SLOW_MULT(SLOW_MULT), .LOOP_INVERT(LOOP_INVERT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineHi(lineHi), .lineLo(lineLo),
    .loopHi(loopHi), .loopLo(loopLo), .selfTest(selfTest),
    .cfgSlow(cfgSlow), .cfgShort(cfgShort), .cfgFilterEn(cfgFilterEn),
    .cfgX(cfgX), .cfgY(cfgY), .strobe(strobe), .sampleTick(sampleTick),
    .candSym(candSym), .heldSym(heldSym), .wordValid(wordValid),
    .wordData(wordData), .parityEven(parityEven)
  );

  arinc_word_rx_ctl #(.GAP_TICKS(GAP_TICKS)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgShort(cfgShort), .sampleTick(sampleTick),
    .candSym(candSym), .heldSym(heldSym), .strobe(strobe)
  );
endmodule

// File: rtl/arinc_word_rx_chk.sv
`timescale 1ns/1ps
module arinc_word_rx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgShort,
  input logic        cfgFilterEn,
  input logic        cfgX,
  input logic        cfgY,
  input logic        wordValid,
  input logic [31:0] wordData,
  input logic        parityEven
);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  p_hold_between_r12: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> ($stable(wordData) && $stable(parityEven)));

  p_short_upper_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && cfgShort) |-> (wordData[31:25] == 7'd0));

  p_filter_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && cfgFilterEn && !cfgShort) |-> (wordData[8] == cfgX && wordData[9] == cfgY));

  p_parity_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (parityEven == ($countones(wordData) % 2 == 0)));
endmodule

bind arinc_word_rx arinc_word_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgShort(cfgShort), .cfgFilterEn(cfgFilterEn),
  .cfgX(cfgX), .cfgY(cfgY), .wordValid(wordValid), .wordData(wordData),
  .parityEven(parityEven)
);

// File: tb/arinc_word_rx_test.sv
`timescale 1ns/1ps
module arinc_word_rx_test;
  localparam int GAP_LIMIT = 20;
  localparam logic [31:0] MASK25 = 32'h01FF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineHi = 1'b0, lineLo = 1'b0, loopHi = 1'b0, loopLo = 1'b0;
  logic selfTest = 1'b0, cfgSlow = 1'b0, cfgShort = 1'b0;
  logic cfgFilterEn = 1'b0, cfgX = 1'b0, cfgY = 1'b0;
  logic        wordValid, invValid, parityEven, invPar;
  logic [31:0] wordData, invData;

  int  nChecks = 0, nFails = 0;
  int  tickClk = 10;
  bit  driveLoop = 1'b0;
  bit  finished = 1'b0;
  int  gotCount = 0, invCount = 0;
  logic [31:0] gotWord, invWord;
  logic        gotPar;

  always #5 clk = ~clk;

  arinc_word_rx uut (
    .clk(clk), .rstN(rstN), .lineHi(lineHi), .lineLo(lineLo), .loopHi(loopHi),
    .loopLo(loopLo), .selfTest(selfTest), .cfgSlow(cfgSlow), .cfgShort(cfgShort),
    .cfgFilterEn(cfgFilterEn), .cfgX(cfgX), .cfgY(cfgY), .wordValid(wordValid),
    .wordData(wordData), .parityEven(parityEven)
  );

  arinc_word_rx #(.LOOP_INVERT(1)) uutInv (
    .clk(clk), .rstN(rstN), .lineHi(lineHi), .lineLo(lineLo), .loopHi(loopHi),
    .loopLo(loopLo), .selfTest(selfTest), .cfgSlow(cfgSlow), .cfgShort(cfgShort),
    .cfgFilterEn(cfgFilterEn), .cfgX(cfgX), .cfgY(cfgY), .wordValid(invValid),
    .wordData(invData), .parityEven(invPar)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // behavioural reference: tick phase, two-sample confirmation, bit queue
  int          mDiv, mNull, mLim, mLen;
  logic [1:0]  mPrev, mStable, mSym, mCand;
  bit          mQ[$];
  bit          mExpValid, mExpPar, mTk, mAcc;
  logic [31:0] mExpWord, mW;

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mNull = 0; mPrev = 2'b00; mStable = 2'b00;
      mQ.delete(); mExpValid = 0; mExpWord = '0; mExpPar = 0;
    end else begin
      mExpValid = 0;
      mLim = cfgSlow ? 79 : 9;
      mLen = cfgShort ? 25 : 32;
      mTk = (mDiv >= mLim);
      mDiv = mTk ? 0 : mDiv + 1;
      if (mTk) begin
        mSym  = selfTest ? {loopHi, loopLo} : {lineHi, lineLo};
        mCand = (mSym == mPrev) ? mSym : mStable;
        if (mCand == 2'b11) begin
          mQ.delete(); mNull = 0;
        end else if (mCand == 2'b00) begin
          if (mStable != 2'b00 && mQ.size() == mLen) begin
            mW = '0;
            for (int i = 0; i < mLen; i++) mW[i] = mQ[i];
            mAcc = !cfgFilterEn || cfgShort || (mW[8] == cfgX && mW[9] == cfgY);
            mQ.delete();
            if (mAcc) begin
              mExpValid = 1; mExpWord = mW; mExpPar = ($countones(mW) % 2 == 0);
            end
          end else if (mQ.size() > 0 && mNull + 1 >= GAP_LIMIT) begin
            mQ.delete();
          end
          mNull++;
        end else begin
          mNull = 0;
          if (mStable == 2'b00 && mQ.size() < mLen) mQ.push_back(mCand == 2'b10);
        end
        mPrev = mSym; mStable = mCand;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(wordValid == mExpValid, "R6 strobe cycle vs model", 32'(wordValid), 32'(mExpValid));
      if (mExpValid) begin
        check(wordData == mExpWord, "R4 word vs model", wordData, mExpWord);
        check(parityEven == mExpPar, "R7 parity vs model", 32'(parityEven), 32'(mExpPar));
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && wordValid) begin gotCount++; gotWord = wordData; gotPar = parityEven; end
    if (rstN && invValid)  begin invCount++; invWord = invData; end
  end

  task automatic putSym(input logic h, input logic l, input int ticks);
    if (driveLoop) begin loopHi = h; loopLo = l; end
    else           begin lineHi = h; lineLo = l; end
    repeat (ticks * tickClk) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] w, input int first, input int last, input int lastNull);
    for (int i = first; i <= last; i++) begin
      putSym(w[i], ~w[i], 5);
      putSym(1'b0, 1'b0, (i == last) ? lastNull : 5);
    end
  endtask

  task automatic sendWord(input logic [31:0] w, input int len);
    sendBits(w, 0, len - 1, 40);
  endtask

  task automatic expectOne(input int c0, input logic [31:0] w, input string tag);
    check(gotCount == c0 + 1, tag, 32'(gotCount), 32'(c0 + 1));
    check(gotWord == w, tag, gotWord, w);
    check(gotPar == ($countones(w) % 2 == 0), {tag, " R7"}, 32'(gotPar), 32'($countones(w) % 2 == 0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int c0;
    logic [31:0] prevWord;
    repeat (3) @(negedge clk);
    check(wordValid == 1'b0, "R1 reset strobe", 32'(wordValid), 32'd0);
    check(wordData == 32'd0, "R1 reset word", wordData, 32'd0);
    check(parityEven == 1'b0, "R1 reset parity", 32'(parityEven), 32'd0);
    rstN = 1'b1;
    putSym(1'b0, 1'b0, 5);

    // R3 R4: 32-bit words, even and odd ones counts
    c0 = gotCount; sendWord(32'hA5C3_1E69, 32); expectOne(c0, 32'hA5C3_1E69, "R3 R4 word even");
    c0 = gotCount; sendWord(32'h1234_5678, 32); expectOne(c0, 32'h1234_5678, "R4 word odd");

    // R5: 25-bit mode, filter code mismatching is ignored there (R8)
    cfgShort = 1'b1; cfgFilterEn = 1'b1; cfgX = 1'b1; cfgY = 1'b1;
    c0 = gotCount; sendWord(32'h00A5_5A5A, 25); expectOne(c0, 32'h00A5_5A5A & MASK25, "R5 R8 short word");
    c0 = gotCount; sendWord(32'hFFFF_FFFF, 25); expectOne(c0, MASK25, "R5 upper bits zero");

    // R8: source/destination match in 32-bit mode
    cfgShort = 1'b0; cfgX = 1'b0; cfgY = 1'b1;
    c0 = gotCount; sendWord(32'h1234_5A00, 32); expectOne(c0, 32'h1234_5A00, "R8 code match");
    c0 = gotCount; prevWord = wordData; sendWord(32'h1234_5900, 32);
    check(gotCount == c0, "R8 mismatch rejected", 32'(gotCount), 32'(c0));
    check(wordData == prevWord, "R12 word held after reject", wordData, prevWord);
    cfgFilterEn = 1'b0;
    c0 = gotCount; sendWord(32'h1234_5900, 32); expectOne(c0, 32'h1234_5900, "R8 filter off");

    // R9: mid-word null of 19 ticks kept, 20 ticks dropped
    c0 = gotCount; sendBits(32'hCAFE_F00D, 0, 11, 19); sendBits(32'hCAFE_F00D, 12, 31, 40);
    expectOne(c0, 32'hCAFE_F00D, "R9 19-tick null kept");
    c0 = gotCount; sendBits(32'h0BAD_BEEF, 0, 11, 20); sendBits(32'h0BAD_BEEF, 12, 31, 40);
    check(gotCount == c0, "R9 20-tick null dropped", 32'(gotCount), 32'(c0));
    c0 = gotCount; sendWord(32'h7E57_0001, 32); expectOne(c0, 32'h7E57_0001, "R9 recovery word");

    // R10: illegal state aborts the partial word
    c0 = gotCount; sendBits(32'hFFFF_FFFF, 0, 9, 5); putSym(1'b1, 1'b1, 3); putSym(1'b0, 1'b0, 10);
    sendWord(32'h3C3C_0F0F, 32); expectOne(c0, 32'h3C3C_0F0F, "R10 illegal aborts");

    // R11: loopback selected, line held illegal, inverted instance sees complement
    selfTest = 1'b1; lineHi = 1'b1; lineLo = 1'b1; driveLoop = 1'b1;
    putSym(1'b0, 1'b0, 5);
    c0 = gotCount;
    begin
      int i0;
      i0 = invCount;
      sendWord(32'h9E37_79B9, 32);
      expectOne(c0, 32'h9E37_79B9, "R11 loop true");
      check(invCount == i0 + 1, "R11 inverted count", 32'(invCount), 32'(i0 + 1));
      check(invWord == ~32'h9E37_79B9, "R11 inverted word", invWord, ~32'h9E37_79B9);
    end
    loopHi = 1'b0; loopLo = 1'b0; lineHi = 1'b0; lineLo = 1'b0;
    selfTest = 1'b0; driveLoop = 1'b0;
    putSym(1'b0, 1'b0, 5);

    // R2: slow rate, 25-bit word
    cfgSlow = 1'b1; tickClk = 80; cfgShort = 1'b1;
    putSym(1'b0, 1'b0, 5);
    c0 = gotCount; sendWord(32'h0155_AA33, 25); expectOne(c0, 32'h0155_AA33 & MASK25, "R2 slow rate");

    finished = 1'b1;
    finishRun();
  end
endmodule